// File: doc/BRIEF.md
# Handshake Mailbox Bridge for a Memory-Mapped Control Bus

This block is an AXI4-Lite slave that carries single 32-bit words between a processor and a downstream engine. The processor drops a word into an inbound data register, then writes a one into the inbound control register. That raises a valid line toward the engine, which holds until the engine answers with an acknowledge. Each write of the set bit is a fresh event, even when the processor sends the same word twice in a row, because the valid bit is cleared by the handshake and not by the processor.

Results travel the other way. The engine pulses a valid strobe with a word. The bridge latches the word and raises an outbound flag, and the processor polls that flag. Reading the flag returns its value and then drops it, so two results in a row are never mistaken for one. Only single-beat accesses are handled.

Top module: `mbox_axil_bridge`

## Requirements
- R1: After a synchronous active-low reset, the inbound word, the inbound flag, the outbound word and the outbound flag are all zero, and `s_bvalid` and `s_rvalid` are low.
- R2: Word offsets 0x00, 0x04, 0x08 and 0x0C read as zero, and writes to them change no register.
- R3: Offset 0x10 holds the inbound word. It is readable and writable, it drives `eng_in_data`, and write strobe bit i updates only bits 8i+7..8i.
- R4: Writing a one to bit 0 of offset 0x14 (with strobe bit 0 set) raises `eng_in_valid` when the write response is issued. Writing a zero there has no effect. Repeating an identical write after a handshake raises the flag again.
- R5: In the cycle where `eng_in_valid` and `eng_in_ack` are both high, the flag drops at the next edge. If a set write lands in that same cycle, the flag stays high.
- R6: A read of offset 0x14 returns the inbound flag in bit 0 and the current `eng_in_ack` in bit 1. All other bits read zero.
- R7: A cycle with `eng_out_vld` high loads `eng_out_data` into offset 0x18 and sets the outbound flag, overwriting any unread word. Bus writes to 0x18 and 0x1C change nothing.
- R8: A read of offset 0x1C returns the outbound flag in bit 0 (other bits zero) as it was before the read. The flag clears when the read data handshake completes, unless `eng_out_vld` is high in that cycle.
- R9: The write address and write data are accepted in either order or together. Every write gets exactly one response with `s_bresp` = 2'b00, and every read returns `s_rresp` = 2'b00.
- R10: `s_bvalid` and `s_rvalid`, once high, stay high with unchanged data until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| eng_in_data | output | DATA_W | Inbound word toward the engine |
| eng_in_valid | output | 1 | Inbound word valid |
| eng_in_ack | input | 1 | Engine acknowledge of the inbound word |
| eng_out_data | input | DATA_W | Result word from the engine |
| eng_out_vld | input | 1 | Result word strobe |

## Verification
The bench targets the corner cases a naive register file gets wrong.

- **Set write coinciding with the acknowledge.** A set write is lined up so that it completes in the same cycle as the engine acknowledge. A design that lets the clear win would silently drop that second event.
- **Repeated identical words.** Identical words are sent twice. A level-compare design would never see the second one.
- **Outbound flag clear timing.** The outbound flag is read twice. A design that clears it when the address is accepted, or not at all, returns the wrong value on one of those reads.
- **Handshake ordering and back-pressure.** Address and data are offered in both orders and with the response held off. A design that requires both in the same cycle hangs. One that lets the response drop loses it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Word index (byte offset divided by four) of each register slot
  localparam int unsigned SLOT_IN_WORD   = 4;
  localparam int unsigned SLOT_IN_CTRL   = 5;
  localparam int unsigned SLOT_OUT_WORD  = 6;
  localparam int unsigned SLOT_OUT_CTRL  = 7;

  // Bit positions inside the control slots
  localparam int unsigned CTRL_VALID_BIT = 0;
  localparam int unsigned CTRL_ACK_BIT   = 1;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/mbox_axil_wr.sv
module mbox_axil_wr #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb
);
  logic aw_held, w_held, bvalid_q;
  logic aw_take, w_take, b_done;

  assign awready = !aw_held && !bvalid_q;
  assign wready  = !w_held && !bvalid_q;
  assign aw_take = awvalid && awready;
  assign w_take  = wvalid && wready;
  assign wr_fire = aw_held && w_held && !bvalid_q;
  assign b_done  = bvalid_q && bready;
  assign bvalid  = bvalid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_held  <= 1'b0;
      w_held   <= 1'b0;
      bvalid_q <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_strb  <= '0;
    end else begin
      if (aw_take) begin
        aw_held <= 1'b1;
        wr_addr <= awaddr;
      end
      if (w_take) begin
        w_held  <= 1'b1;
        wr_data <= wdata;
        wr_strb <= wstrb;
      end
      if (wr_fire) begin
        aw_held  <= 1'b0;
        w_held   <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (b_done) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  // R9
  resp_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> bvalid);
  // R10
  bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);
  // R9
  no_accept_while_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (!awready && !wready));
endmodule

// File: rtl/mbox_axil_rd.sv
module mbox_axil_rd #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  input  logic              rready,
  input  logic [DATA_W-1:0] rd_word,
  output logic              rd_done,
  output logic [ADDR_W-1:0] rd_done_addr
);
  logic rvalid_q, ar_take;

  assign arready = !rvalid_q;
  assign ar_take = arvalid && arready;
  assign rvalid  = rvalid_q;
  assign rd_done = rvalid_q && rready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q     <= 1'b0;
      rdata        <= '0;
      rd_done_addr <= '0;
    end else if (ar_take) begin
      rvalid_q     <= 1'b1;
      rdata        <= rd_word;
      rd_done_addr <= araddr;
    end else if (rd_done) begin
      rvalid_q <= 1'b0;
    end
  end

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
  // R10
  rvalid_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_take |=> rvalid);
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STRB_W-1:0] wr_strb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  input  logic              rd_done,
  input  logic [ADDR_W-1:0] rd_done_addr,
  output logic [DATA_W-1:0] in_data,
  output logic              in_valid,
  input  logic              in_ack,
  input  logic [DATA_W-1:0] out_word_in,
  input  logic              out_strobe
);
  logic [DATA_W-1:0] out_data;
  logic              out_valid;

  // True when a byte address falls on the given word slot
  function automatic logic hits(input logic [ADDR_W-1:0] addr, input int unsigned slot);
    return (addr >> 2) == ADDR_W'(slot);
  endfunction

  // Byte-lane merge of a strobed write onto the old word
  function automatic logic [DATA_W-1:0] merge_bytes(input logic [DATA_W-1:0] old_w,
                                                    input logic [DATA_W-1:0] new_w,
                                                    input logic [STRB_W-1:0] strb);
    logic [DATA_W-1:0] res;
    for (int b = 0; b < STRB_W; b++) begin
      res[8*b +: 8] = strb[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    end
    return res;
  endfunction

  // Named internal events
  logic wr_in_word, set_in, hs_in, cap_out, clr_out, wr_reserved;

  assign wr_in_word  = wr_fire && hits(wr_addr, SLOT_IN_WORD);
  assign set_in      = wr_fire && hits(wr_addr, SLOT_IN_CTRL)
                       && wr_strb[0] && wr_data[CTRL_VALID_BIT];
  assign hs_in       = in_valid && in_ack;
  assign cap_out     = out_strobe;
  assign clr_out     = rd_done && hits(rd_done_addr, SLOT_OUT_CTRL);
  assign wr_reserved = wr_fire && ((wr_addr >> 2) < ADDR_W'(SLOT_IN_WORD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_data   <= '0;
      in_valid  <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      if (wr_in_word) in_data <= merge_bytes(in_data, wr_data, wr_strb);
      if (set_in)     in_valid <= 1'b1;
      else if (hs_in) in_valid <= 1'b0;
      if (cap_out) begin
        out_data  <= out_word_in;
        out_valid <= 1'b1;
      end else if (clr_out) begin
        out_valid <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (hits(rd_addr, SLOT_IN_WORD)) begin
      rd_word = in_data;
    end else if (hits(rd_addr, SLOT_IN_CTRL)) begin
      rd_word[CTRL_VALID_BIT] = in_valid;
      rd_word[CTRL_ACK_BIT]   = in_ack;
    end else if (hits(rd_addr, SLOT_OUT_WORD)) begin
      rd_word = out_data;
    end else if (hits(rd_addr, SLOT_OUT_CTRL)) begin
      rd_word[CTRL_VALID_BIT] = out_valid;
    end
  end

  // R5
  hs_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_in && !set_in) |=> !in_valid);
  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_in |=> in_valid);
  // R7
  out_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_out |=> (out_valid && out_data == $past(out_word_in)));
  // R8
  out_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_out && !cap_out) |=> !out_valid);
  // R2
  reserved_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reserved && !hs_in) |=> ($stable(in_data) && $stable(in_valid)));
endmodule

// File: rtl/mbox_axil_bridge.sv
module mbox_axil_bridge
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] eng_in_data,
  output logic              eng_in_valid,
  input  logic              eng_in_ack,
  input  logic [DATA_W-1:0] eng_out_data,
  input  logic              eng_out_vld
);
  logic              wr_fire;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [STRB_W-1:0] wr_strb;
  logic [DATA_W-1:0] rd_word;
  logic              rd_done;
  logic [ADDR_W-1:0] rd_done_addr;

  assign s_bresp = RESP_OKAY;
  assign s_rresp = RESP_OKAY;

  mbox_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bvalid(s_bvalid), .bready(s_bready),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  mbox_axil_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready),
    .rd_word(rd_word), .rd_done(rd_done), .rd_done_addr(rd_done_addr)
  );

  mbox_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_addr(s_araddr), .rd_word(rd_word),
    .rd_done(rd_done), .rd_done_addr(rd_done_addr),
    .in_data(eng_in_data), .in_valid(eng_in_valid), .in_ack(eng_in_ack),
    .out_word_in(eng_out_data), .out_strobe(eng_out_vld)
  );
endmodule

// File: tb/tb_mbox_axil_bridge.sv
module tb_mbox_axil_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  s_awaddr = '0;
  logic        s_awvalid = 1'b0;
  logic        s_awready;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_wvalid = 1'b0;
  logic        s_wready;
  logic [1:0]  s_bresp;
  logic        s_bvalid;
  logic        s_bready = 1'b1;
  logic [4:0]  s_araddr = '0;
  logic        s_arvalid = 1'b0;
  logic        s_arready;
  logic [31:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rvalid;
  logic        s_rready = 1'b1;
  logic [31:0] eng_in_data;
  logic        eng_in_valid;
  logic        eng_in_ack = 1'b0;
  logic [31:0] eng_out_data = '0;
  logic        eng_out_vld = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  mbox_axil_bridge dut (.*);

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each completed read beat with the queued expectation
  always @(negedge clk) begin
    if (rst_n && s_rvalid && s_rready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected read beat", s_rdata, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(s_rdata === e.val, e.tag, s_rdata, e.val);
        check(s_rresp === 2'b00, "R9 rresp", {30'd0, s_rresp}, 32'h0);
      end
    end
  end

  // order: 0 together, 1 address first, 2 data first
  task automatic axi_write(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s, input int order);
    @(negedge clk);
    if (order == 0) begin
      s_awaddr = a; s_awvalid = 1'b1; s_wdata = d; s_wstrb = s; s_wvalid = 1'b1;
      while (!(s_awready && s_wready)) @(negedge clk);
      @(negedge clk);
      s_awvalid = 1'b0; s_wvalid = 1'b0;
    end else if (order == 1) begin
      s_awaddr = a; s_awvalid = 1'b1;
      while (!s_awready) @(negedge clk);
      @(negedge clk);
      s_awvalid = 1'b0;
      repeat (2) @(negedge clk);
      check(!s_bvalid, "R9 no response before data", {31'd0, s_bvalid}, 32'h0);
      s_wdata = d; s_wstrb = s; s_wvalid = 1'b1;
      while (!s_wready) @(negedge clk);
      @(negedge clk);
      s_wvalid = 1'b0;
    end else begin
      s_wdata = d; s_wstrb = s; s_wvalid = 1'b1;
      while (!s_wready) @(negedge clk);
      @(negedge clk);
      s_wvalid = 1'b0;
      repeat (2) @(negedge clk);
      check(!s_bvalid, "R9 no response before address", {31'd0, s_bvalid}, 32'h0);
      s_awaddr = a; s_awvalid = 1'b1;
      while (!s_awready) @(negedge clk);
      @(negedge clk);
      s_awvalid = 1'b0;
    end
    while (!s_bvalid) @(negedge clk);
    check(s_bresp === 2'b00, "R9 bresp", {30'd0, s_bresp}, 32'h0);
    if (s_bready) @(negedge clk);
  endtask

  task automatic axi_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1'b1;
    while (!s_arready) @(negedge clk);
    @(negedge clk);
    s_arvalid = 1'b0;
    while (!(s_rvalid && s_rready)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic eng_result(input logic [31:0] d);
    @(negedge clk);
    eng_out_data = d; eng_out_vld = 1'b1;
    @(negedge clk);
    eng_out_vld = 1'b0;
  endtask

  task automatic engine_ack();
    @(negedge clk);
    eng_in_ack = 1'b1;
    @(negedge clk);
    check(eng_in_valid === 1'b0, "R5 valid dropped after ack", {31'd0, eng_in_valid}, 32'h0);
    eng_in_ack = 1'b0;
  endtask

  task automatic finish_run();
    check(exp_q.size() == 0, "R9 all reads answered", exp_q.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(eng_in_valid === 1'b0, "R1 in_valid", {31'd0, eng_in_valid}, 32'h0);
    check(eng_in_data === 32'h0, "R1 in_data", eng_in_data, 32'h0);
    check(!s_bvalid && !s_rvalid, "R1 no responses", {30'd0, s_bvalid, s_rvalid}, 32'h0);
    axi_read(5'h10, 32'h0, "R1 inbound word");
    axi_read(5'h14, 32'h0, "R1 inbound ctrl");
    axi_read(5'h18, 32'h0, "R1 outbound word");
    axi_read(5'h1C, 32'h0, "R1 outbound ctrl");

    // R3 data word with strobes
    axi_write(5'h10, 32'hA5A5_1234, 4'hF, 0);
    check(eng_in_data === 32'hA5A5_1234, "R3 in_data full", eng_in_data, 32'hA5A5_1234);
    axi_write(5'h10, 32'hFFFF_FFFF, 4'b0011, 0);
    axi_read(5'h10, 32'hA5A5_FFFF, "R3 low half strobe");
    axi_write(5'h10, 32'h7700_0000, 4'b1000, 0);
    axi_read(5'h10, 32'h77A5_FFFF, "R3 top byte strobe");

    // R4 set bit, zero write ignored
    axi_write(5'h14, 32'h0, 4'hF, 0);
    check(eng_in_valid === 1'b0, "R4 zero write ignored", {31'd0, eng_in_valid}, 32'h0);
    axi_write(5'h14, 32'h1, 4'hF, 0);
    check(eng_in_valid === 1'b1, "R4 set raises valid", {31'd0, eng_in_valid}, 32'h1);
    axi_read(5'h14, 32'h1, "R6 ctrl shows valid");
    // R5 handshake, R6 ack bit
    @(negedge clk);
    eng_in_ack = 1'b1;
    @(negedge clk);
    check(eng_in_valid === 1'b0, "R5 handshake clears", {31'd0, eng_in_valid}, 32'h0);
    axi_read(5'h14, 32'h2, "R6 ack bit");
    eng_in_ack = 1'b0;

    // R4 same word and same set write again: new event
    axi_write(5'h10, 32'h77A5_FFFF, 4'hF, 0);
    axi_write(5'h14, 32'h1, 4'hF, 0);
    check(eng_in_valid === 1'b1, "R4 repeat write new event", {31'd0, eng_in_valid}, 32'h1);
    check(eng_in_data === 32'h77A5_FFFF, "R4 word unchanged", eng_in_data, 32'h77A5_FFFF);

    // R5 set write lands in the handshake cycle
    @(negedge clk);
    s_awaddr = 5'h14; s_awvalid = 1'b1; s_wdata = 32'h1; s_wstrb = 4'hF; s_wvalid = 1'b1;
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    eng_in_ack = 1'b1;
    @(negedge clk);
    check(eng_in_valid === 1'b1, "R5 set wins over handshake", {31'd0, eng_in_valid}, 32'h1);
    check(s_bvalid === 1'b1, "R9 response with collision", {31'd0, s_bvalid}, 32'h1);
    @(negedge clk);
    check(eng_in_valid === 1'b0, "R5 later handshake clears", {31'd0, eng_in_valid}, 32'h0);
    eng_in_ack = 1'b0;

    // R2 reserved slots
    axi_write(5'h00, 32'hFFFF_FFFF, 4'hF, 0);
    axi_write(5'h04, 32'hFFFF_FFFF, 4'hF, 0);
    axi_write(5'h08, 32'hFFFF_FFFF, 4'hF, 0);
    axi_write(5'h0C, 32'hFFFF_FFFF, 4'hF, 0);
    check(eng_in_valid === 1'b0, "R2 reserved write no set", {31'd0, eng_in_valid}, 32'h0);
    check(eng_in_data === 32'h77A5_FFFF, "R2 reserved write no data", eng_in_data, 32'h77A5_FFFF);
    axi_read(5'h00, 32'h0, "R2 read 0x00");
    axi_read(5'h04, 32'h0, "R2 read 0x04");
    axi_read(5'h08, 32'h0, "R2 read 0x08");
    axi_read(5'h0C, 32'h0, "R2 read 0x0C");

    // R6 upper control bits read zero
    axi_write(5'h14, 32'hFFFF_FFFF, 4'hF, 0);
    axi_read(5'h14, 32'h1, "R6 other bits zero");
    engine_ack();

    // R7 capture, R8 read-clear
    eng_result(32'hCAFE_0001);
    axi_read(5'h18, 32'hCAFE_0001, "R7 captured word");
    axi_write(5'h18, 32'hDEAD_BEEF, 4'hF, 0);
    axi_write(5'h1C, 32'h0, 4'hF, 0);
    axi_read(5'h18, 32'hCAFE_0001, "R7 write to result ignored");
    axi_read(5'h1C, 32'h1, "R8 flag before clear");
    axi_read(5'h1C, 32'h0, "R8 flag cleared by read");
    eng_result(32'h0000_0011);
    eng_result(32'h0000_0022);
    axi_read(5'h18, 32'h0000_0022, "R7 overwrite");
    axi_read(5'h1C, 32'h1, "R8 flag set again");

    // R9 orders
    axi_write(5'h10, 32'h1111_2222, 4'hF, 1);
    check(eng_in_data === 32'h1111_2222, "R9 address first", eng_in_data, 32'h1111_2222);
    axi_write(5'h10, 32'h3333_4444, 4'hF, 2);
    check(eng_in_data === 32'h3333_4444, "R9 data first", eng_in_data, 32'h3333_4444);

    // R10 back-pressure on write response
    s_bready = 1'b0;
    axi_write(5'h10, 32'h5555_6666, 4'hF, 0);
    repeat (3) @(negedge clk);
    check(s_bvalid === 1'b1, "R10 bvalid held", {31'd0, s_bvalid}, 32'h1);
    s_bready = 1'b1;
    @(negedge clk);
    check(s_bvalid === 1'b0, "R10 bvalid released", {31'd0, s_bvalid}, 32'h0);

    // R10 back-pressure on read data
    s_rready = 1'b0;
    begin
      exp_t e;
      e.val = 32'h5555_6666; e.tag = "R10 held read data";
      exp_q.push_back(e);
    end
    @(negedge clk);
    s_araddr = 5'h10; s_arvalid = 1'b1;
    @(negedge clk);
    s_arvalid = 1'b0;
    repeat (3) @(negedge clk);
    check(s_rvalid === 1'b1, "R10 rvalid held", {31'd0, s_rvalid}, 32'h1);
    s_rready = 1'b1;
    repeat (2) @(negedge clk);
    check(s_rvalid === 1'b0, "R10 rvalid released", {31'd0, s_rvalid}, 32'h0);

    finish_run();
  end
endmodule